// File: doc/BRIEF.md
# Ones-Complement Packet Checksum Engine

This block computes a 16-bit ones-complement checksum over packets that arrive one byte per cycle, framed by a start marker and an end marker. Each packet carries a 16-byte header with a fixed layout. The destination address is at bytes 4–5, the source address at bytes 8–9, and byte 1 must be zero. The engine reads these fields as the bytes stream past, so it needs no packet buffer.

For an outgoing packet (transmit mode latched at the start byte), the engine emits a four-byte trailer right after the last payload byte. The trailer holds a copy of the source address, high byte first, and then the checksum, high byte first. The checksum covers the payload and the two copied source bytes. A payload that is too long gets no trailer and raises a length error instead.

For an incoming packet, the engine sums every byte, trailer included, and raises a checksum error when the complemented result is not zero. It also reports whether the packet is addressed to this node. It reports a header error when the must-be-zero byte is not zero.

Top module: `cks_engine`

## Requirements
- R1: Bytes are paired in arrival order into 16-bit words, with the first byte of the pair as the high byte. Words are added with end-around carry, so a carry out of bit 15 is added back into bit 0.
- R2: When a summed stream has an odd number of bytes, its final byte is added as the value 0x00nn and is not shifted into the high byte.
- R3: On receive, `rx_done` pulses in the cycle after the last byte is accepted. In that cycle, `rx_crc_err` is 1 exactly when the bitwise complement of the folded sum over all packet bytes is not 0x0000.
- R4: On transmit with an allowed length, `tx_valid` and `busy` are high for the four cycles that follow the last payload byte. `tx_data` carries, in order: header byte 8, header byte 9, checksum high byte, checksum low byte. `tx_last` is high only on the fourth of these cycles. Header bytes the packet did not reach read as 0x00.
- R5: The transmit checksum is the complement of the folded sum over the payload followed by the two copied source bytes. Byte pairing runs across the join between payload and copied bytes.
- R6: `rx_accept` is 1 in the `rx_done` cycle when the destination word is accepted. The destination word is header byte 4 as the high byte and byte 5 as the low byte. It is accepted when it equals `node_addr`, when it is 0x0000, or when `spy_en` is 1. Header bytes the packet did not reach count as 0x00.
- R7: A transmit payload longer than MAX_TX_BYTES (508) bytes makes `tx_len_err` pulse in the cycle after the last byte, and no trailer is sent.
- R8: `rx_hdr_err` is 1 in the `rx_done` cycle when header byte 1 is not zero. This does not change `rx_accept`.
- R9: Input bytes are ignored while a trailer is being emitted, and also outside a packet unless they carry `in_first`. A start marker is likewise ignored during a trailer.
- R10: While reset is held, `tx_valid`, `tx_last`, `busy`, `rx_done`, `rx_crc_err`, `rx_accept`, `rx_hdr_err` and `tx_len_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a packet |
| in_last | input | 1 | Byte is the last of a packet |
| tx_mode | input | 1 | Sampled with in_first: 1 transmit, 0 receive |
| node_addr | input | 16 | This node's address for receive filtering |
| spy_en | input | 1 | Accept every received packet |
| tx_valid | output | 1 | Trailer byte present |
| tx_data | output | 8 | Trailer byte |
| tx_last | output | 1 | Final trailer byte |
| busy | output | 1 | Trailer in progress, inputs ignored |
| rx_done | output | 1 | Receive result strobe |
| rx_crc_err | output | 1 | Receive checksum error |
| rx_accept | output | 1 | Packet addressed to this node |
| rx_hdr_err | output | 1 | Must-be-zero header byte was nonzero |
| tx_len_err | output | 1 | Transmit payload too long |

## Verification
The bench uses a single packet of three bytes, FF 00 FF, whose checksum is zero only when the odd byte is added at the low end. A design that shifted that byte up would report a checksum error on a good packet. Odd-length transmit payloads check that pairing runs across the join into the copied source bytes; a design that restarted the pairing there would emit a wrong checksum. Payloads of all 0xFF bytes exercise end-around carry, and payloads of exactly 508 and 509 bytes probe the length limit from both sides. Garbage bytes, including start markers, are driven during a trailer and stray bytes outside any packet; a design that let them in would corrupt the trailer or raise a spurious result.

// File: rtl/cks_pkg.sv
package cks_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_T0,
        ST_T1,
        ST_T2,
        ST_T3
    } seq_e;

    // 16-bit ones-complement add with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/cks_accum.sv
module cks_accum
    import cks_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        first,
    input  logic        last_b,
    input  logic [7:0]  din,
    output logic [15:0] sum_q,
    output logic        have_q
);

    typedef struct packed {
        logic [15:0] sum;
        logic [7:0]  hi;
        logic        have;
    } acc_s;

    acc_s r_q, r_d;
    logic [15:0] base_sum;
    logic        base_have;

    always_comb begin
        r_d       = r_q;
        base_sum  = first ? 16'h0000 : r_q.sum;
        base_have = first ? 1'b0 : r_q.have;
        if (en) begin
            r_d.sum  = base_sum;
            r_d.have = base_have;
            if (base_have) begin
                r_d.sum  = oc_add(base_sum, {r_q.hi, din});
                r_d.have = 1'b0;
            end else if (last_b) begin
                r_d.sum = oc_add(base_sum, {8'h00, din});
            end else begin
                r_d.hi   = din;
                r_d.have = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sum_q  = r_q.sum;
    assign have_q = r_q.have;

    AST_NO_PENDING_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last_b) |=> !have_q); // R2

endmodule

// File: rtl/cks_hdr.sv
module cks_hdr #(
    parameter int PW      = 10,
    parameter int MBZ_OFS = 1,
    parameter int DST_OFS = 4,
    parameter int SRC_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    din,
    output logic [15:0]   dst_q,
    output logic [15:0]   src_q,
    output logic          mbz_bad_q
);

    typedef struct packed {
        logic [15:0] dst;
        logic [15:0] src;
        logic        mbz_bad;
    } hdr_s;

    hdr_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (en) begin
            if (first) begin
                r_d = '0;
            end
            if (pos == PW'(MBZ_OFS))     r_d.mbz_bad  = (din != 8'h00);
            if (pos == PW'(DST_OFS))     r_d.dst[15:8] = din;
            if (pos == PW'(DST_OFS + 1)) r_d.dst[7:0]  = din;
            if (pos == PW'(SRC_OFS))     r_d.src[15:8] = din;
            if (pos == PW'(SRC_OFS + 1)) r_d.src[7:0]  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dst_q     = r_q.dst;
    assign src_q     = r_q.src;
    assign mbz_bad_q = r_q.mbz_bad;

    AST_DST_CLEARED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first) |=> (dst_q == 16'h0000)); // R6

endmodule

// File: rtl/cks_engine.sv
module cks_engine
    import cks_pkg::*;
#(
    parameter int MAX_TX_BYTES = 508,
    parameter int MBZ_OFS      = 1,
    parameter int DST_OFS      = 4,
    parameter int SRC_OFS      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_first,
    input  logic        in_last,
    input  logic        tx_mode,
    input  logic [15:0] node_addr,
    input  logic        spy_en,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        busy,
    output logic        rx_done,
    output logic        rx_crc_err,
    output logic        rx_accept,
    output logic        rx_hdr_err,
    output logic        tx_len_err
);

    localparam int CW = $clog2(MAX_TX_BYTES + 1) + 1;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] LEN_LIM = CW'(MAX_TX_BYTES);

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic          rx_done;
        logic          len_err;
    } seq_s;

    seq_s r_q, r_d;

    logic          trl, in_pkt, take, is_tx;
    logic [CW-1:0] pos;
    logic          acc_en, acc_first, acc_last;
    logic [7:0]    acc_din;
    logic [15:0]   acc_sum;
    logic          acc_have;
    logic [15:0]   hdr_dst, hdr_src;
    logic          hdr_mbz;
    logic [15:0]   cks;

    // byte admission
    always_comb begin
        trl    = (r_q.st == ST_T0) || (r_q.st == ST_T1) ||
                 (r_q.st == ST_T2) || (r_q.st == ST_T3);
        in_pkt = (r_q.st == ST_RX) || (r_q.st == ST_TX);
        take   = in_valid && !trl && (in_first || in_pkt);
        is_tx  = in_first ? tx_mode : (r_q.st == ST_TX);
        pos    = in_first ? '0 : r_q.cnt;
    end

    // accumulator feed: input bytes, or the copied source bytes in the trailer
    always_comb begin
        acc_en    = take || (r_q.st == ST_T0) || (r_q.st == ST_T1);
        acc_first = take && in_first;
        acc_last  = take ? (in_last && !is_tx) : (r_q.st == ST_T1);
        if (take)                   acc_din = in_data;
        else if (r_q.st == ST_T0)   acc_din = hdr_src[15:8];
        else                        acc_din = hdr_src[7:0];
    end

    cks_accum u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (acc_en),
        .first  (acc_first),
        .last_b (acc_last),
        .din    (acc_din),
        .sum_q  (acc_sum),
        .have_q (acc_have)
    );

    cks_hdr #(
        .PW      (CW),
        .MBZ_OFS (MBZ_OFS),
        .DST_OFS (DST_OFS),
        .SRC_OFS (SRC_OFS)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (take),
        .first     (in_first),
        .pos       (pos),
        .din       (in_data),
        .dst_q     (hdr_dst),
        .src_q     (hdr_src),
        .mbz_bad_q (hdr_mbz)
    );

    // sequencer
    always_comb begin
        r_d         = r_q;
        r_d.rx_done = 1'b0;
        r_d.len_err = 1'b0;
        unique case (r_q.st)
            ST_T0: r_d.st = ST_T1;
            ST_T1: r_d.st = ST_T2;
            ST_T2: r_d.st = ST_T3;
            ST_T3: r_d.st = ST_IDLE;
            default: begin
                if (take) begin
                    r_d.cnt = (pos == CNT_MAX) ? pos : pos + 1'b1;
                    r_d.st  = is_tx ? ST_TX : ST_RX;
                    if (in_last) begin
                        if (is_tx) begin
                            if (pos >= LEN_LIM) begin
                                r_d.len_err = 1'b1;
                                r_d.st      = ST_IDLE;
                            end else begin
                                r_d.st = ST_T0;
                            end
                        end else begin
                            r_d.rx_done = 1'b1;
                            r_d.st      = ST_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, rx_done: 1'b0, len_err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // outputs
    assign cks = ~acc_sum;

    always_comb begin
        unique case (r_q.st)
            ST_T0:   tx_data = hdr_src[15:8];
            ST_T1:   tx_data = hdr_src[7:0];
            ST_T2:   tx_data = cks[15:8];
            ST_T3:   tx_data = cks[7:0];
            default: tx_data = 8'h00;
        endcase
    end

    assign tx_valid   = trl;
    assign tx_last    = (r_q.st == ST_T3);
    assign busy       = trl;
    assign rx_done    = r_q.rx_done;
    assign rx_crc_err = r_q.rx_done && (cks != 16'h0000);
    assign rx_accept  = r_q.rx_done &&
                        ((hdr_dst == node_addr) || (hdr_dst == 16'h0000) || spy_en);
    assign rx_hdr_err = r_q.rx_done && hdr_mbz;
    assign tx_len_err = r_q.len_err;

    AST_TRAILER_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid); // R4
    AST_TRAILER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |=> !tx_valid); // R4
    AST_LEN_ERR_NO_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_len_err |=> !tx_valid); // R7
    AST_SRC_HELD_IN_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_last) |=> $stable(hdr_src)); // R9
    AST_NO_PAIR_LEFT_AT_CKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |-> !acc_have); // R5
    AST_RX_FLAGS_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> !(rx_crc_err || rx_accept || rx_hdr_err)); // R3

endmodule

// File: tb/cks_engine_tb.sv
module cks_engine_tb;

    typedef byte unsigned bq_t[$];

    localparam int MAXTX = 508;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        tx_mode = 1'b0;
    logic [15:0] node_addr = 16'h0A21;
    logic        spy_en = 1'b0;
    logic        tx_valid, tx_last, busy, rx_done, rx_crc_err, rx_accept, rx_hdr_err, tx_len_err;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    cks_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .tx_mode(tx_mode),
        .node_addr(node_addr), .spy_en(spy_en), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .busy(busy), .rx_done(rx_done),
        .rx_crc_err(rx_crc_err), .rx_accept(rx_accept), .rx_hdr_err(rx_hdr_err),
        .tx_len_err(tx_len_err)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    // expected events keyed by the cycle count seen at the falling edge
    logic [10:0] ev_tx[int];   // {idx[1:0], last, data}
    logic [2:0]  ev_rx[int];   // {crc, accept, hdr}
    string       ev_tag[int];
    bit          ev_len[int];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    function automatic int ocsum(bq_t q);
        int s = 0;
        for (int i = 0; i + 1 < q.size(); i += 2) s += int'(q[i]) * 256 + int'(q[i+1]);
        if (q.size() % 2 == 1) s += int'(q[q.size()-1]);
        while ((s >> 16) != 0) s = (s & 'hFFFF) + (s >> 16);
        return (~s) & 'hFFFF;
    endfunction

    function automatic bq_t trailer(bq_t q);
        bq_t full = q;
        bq_t t;
        int c;
        byte unsigned sh = (q.size() > 8) ? q[8] : 8'h00;
        byte unsigned sl = (q.size() > 9) ? q[9] : 8'h00;
        full.push_back(sh);
        full.push_back(sl);
        c = ocsum(full);
        t.push_back(sh);
        t.push_back(sl);
        t.push_back(8'((c >> 8) & 'hFF));
        t.push_back(8'(c & 'hFF));
        return t;
    endfunction

    function automatic bq_t mk(int dst, int src, int mbz, int plen, int seed, bit all_ff);
        bq_t q;
        q.push_back(8'h05); q.push_back(8'(mbz));
        q.push_back(8'((plen >> 8) & 'h0F)); q.push_back(8'(plen & 'hFF));
        q.push_back(8'(dst >> 8)); q.push_back(8'(dst & 'hFF));
        q.push_back(8'h01); q.push_back(8'h02);
        q.push_back(8'(src >> 8)); q.push_back(8'(src & 'hFF));
        q.push_back(8'h03); q.push_back(8'h04);
        q.push_back(8'h00); q.push_back(8'h11);
        q.push_back(8'h00); q.push_back(8'h22);
        for (int i = 0; i < plen; i++) q.push_back(all_ff ? 8'hFF : 8'((i * 37 + seed) & 'hFF));
        return q;
    endfunction

    function automatic bq_t cat(bq_t a, bq_t b);
        bq_t r = a;
        foreach (b[i]) r.push_back(b[i]);
        return r;
    endfunction

    task automatic send(bit txm, bq_t q, bit gaps, string tag);
        int L = 0;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = q[i]; in_first = (i == 0);
            in_last = (i == q.size() - 1); tx_mode = txm;
            L = cyc;
            if (gaps && i != q.size() - 1 && i % 3 == 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
            end
        end
        if (txm) begin
            if (q.size() > MAXTX) begin
                ev_len[L+1] = 1'b1;
            end else begin
                bq_t t = trailer(q);
                for (int k = 0; k < 4; k++) begin
                    ev_tx[L+1+k] = {2'(k), (k == 3), t[k]};
                    ev_tag[L+1+k] = tag;
                end
            end
        end else begin
            int d = 0;
            bit acc;
            if (q.size() > 4) d = int'(q[4]) * 256;
            if (q.size() > 5) d += int'(q[5]);
            acc = (d == int'(node_addr)) || (d == 0) || spy_en;
            ev_rx[L+1] = {ocsum(q) != 0, acc, (q.size() > 1) && (q[1] != 0)};
            ev_tag[L+1] = tag;
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // per-cycle comparison against the reference schedule
    always @(negedge clk) begin : mon
        logic [10:0] e;
        logic [2:0]  f;
        bit          has;
        if (mon_on) begin
            has = ev_tx.exists(cyc);
            chk("R4 tx_valid", tx_valid, has);
            chk("R4 busy", busy, has);
            if (has) begin
                e = ev_tx[cyc];
                chk(e[10:9] < 2 ? "R4 src copy" : {ev_tag[cyc], " checksum byte"}, tx_data, e[7:0]);
                chk("R4 tx_last", tx_last, e[8]);
            end
            has = ev_rx.exists(cyc);
            chk("R3 rx_done", rx_done, has);
            if (has) begin
                f = ev_rx[cyc];
                chk({ev_tag[cyc], " crc"}, rx_crc_err, f[2]);
                chk("R6 accept", rx_accept, f[1]);
                chk("R8 hdr_err", rx_hdr_err, f[0]);
            end
            chk("R7 tx_len_err", tx_len_err, ev_len.exists(cyc));
        end
    end

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bq_t p, q, t;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 tx_valid", tx_valid, 0);
        chk("R10 busy", busy, 0);
        chk("R10 rx_done", rx_done, 0);
        chk("R10 flags", {rx_crc_err, rx_accept, rx_hdr_err, tx_last}, 0);
        chk("R10 tx_len_err", tx_len_err, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R3 good packet to this node, checksum zero
        p = mk(16'h0A21, 16'h1357, 0, 12, 3, 0);
        send(0, cat(p, trailer(p)), 0, "R3");
        idle(3);
        // R3 corrupted packet
        q = cat(p, trailer(p));
        q[20] = q[20] ^ 8'h10;
        send(0, q, 0, "R3");
        idle(3);
        // R2 three-byte packet that sums to zero only with low-order odd byte
        q = {};
        q.push_back(8'hFF); q.push_back(8'h00); q.push_back(8'hFF);
        send(0, q, 0, "R2");
        idle(3);
        // R2 odd-length receive packet with gaps
        send(0, mk(16'h0A21, 16'h2222, 0, 7, 9, 0), 1, "R2");
        idle(3);
        // R6 broadcast, foreign, spy
        p = mk(16'h0000, 16'h0101, 0, 4, 1, 0);
        send(0, cat(p, trailer(p)), 0, "R6");
        idle(3);
        p = mk(16'h0B00, 16'h0101, 0, 4, 2, 0);
        send(0, cat(p, trailer(p)), 0, "R6");
        idle(3);
        spy_en = 1'b1;
        idle(2);
        send(0, cat(p, trailer(p)), 0, "R6");
        idle(3);
        spy_en = 1'b0;
        idle(2);
        // R8 nonzero must-be-zero byte, still accepted
        p = mk(16'h0A21, 16'h0303, 8'h5A, 6, 4, 0);
        send(0, cat(p, trailer(p)), 0, "R8");
        idle(3);
        // R6 short packet: destination not reached reads as zero
        q = {};
        q.push_back(8'h01); q.push_back(8'h00); q.push_back(8'h07);
        q.push_back(8'h09);
        send(0, q, 0, "R6");
        idle(3);
        // R1 all-ones payload, end-around carry
        p = mk(16'h0A21, 16'hFFFF, 0, 40, 0, 1);
        send(0, cat(p, trailer(p)), 0, "R1");
        idle(3);
        send(1, p, 0, "R1");
        idle(7);
        // R5 transmit even and odd payloads
        p = mk(16'h0C0C, 16'hBEEF, 0, 20, 5, 0);
        send(1, p, 0, "R5");
        idle(7);
        q = mk(16'h0C0C, 16'hCAFE, 0, 17, 6, 0);
        send(1, q, 1, "R5");
        idle(7);
        // R5 loopback: transmitted trailer verifies on receive
        send(0, cat(p, trailer(p)), 0, "R5");
        idle(3);
        // R4 packet shorter than the source field: zero copy
        q = {};
        q.push_back(8'h12); q.push_back(8'h34); q.push_back(8'h56);
        send(1, q, 0, "R4");
        idle(7);
        // R7 boundary lengths
        p = mk(16'h0A21, 16'h4444, 0, MAXTX - 16, 7, 0);
        send(1, p, 0, "R7");
        idle(7);
        p = mk(16'h0A21, 16'h4444, 0, MAXTX - 15, 7, 0);
        send(1, p, 0, "R7");
        idle(7);
        // R9 garbage during a trailer and stray bytes outside a packet
        p = mk(16'h0A21, 16'h5A5A, 0, 8, 8, 0);
        send(1, p, 0, "R9");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(8'hA0 + k); in_first = (k % 2 == 0);
            in_last = 1'b1; tx_mode = (k < 2);
        end
        idle(3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'h77; in_first = 1'b0; in_last = (k == 2);
        end
        idle(3);
        q = mk(16'h0A21, 16'h6161, 0, 10, 2, 0);
        send(0, cat(q, trailer(q)), 0, "R9");
        idle(3);
        // R3 back-to-back receive packets
        p = mk(16'h0A21, 16'h0F0F, 0, 2, 11, 0);
        send(0, cat(p, trailer(p)), 0, "R3");
        send(0, mk(16'h0B0B, 16'h0F0F, 0, 3, 12, 0), 0, "R3");
        idle(5);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule